// File: doc/BRIEF.md
# Single and Double Tap Detector

This block watches a set of per-axis acceleration magnitudes and decides, axis by axis, whether the motion was a single tap or a double tap. Magnitudes arrive with a sample strobe, and a separate one-millisecond tick drives all timing. Each axis has its own threshold. A pulse starts on a sample whose magnitude is strictly above that threshold. The pulse only counts as a tap if a later sample falls back to or below the threshold before a programmable number of ticks has passed.

When double taps are enabled for an axis, a valid first tap opens a quiet period, during which every crossing is ignored. A window for a second tap follows it. A second valid tap that starts inside the window raises that axis's double-tap flag. If the window runs out first, the axis raises its single-tap flag, provided single taps are enabled. When only single taps are enabled, the single flag is raised as soon as the pulse falls.

The flags either clear on the next sample strobe or, in latched mode, stay set until a read strobe clears them. An interrupt-active output shows that any flag is set. An interrupt line with a polarity chosen by a parameter follows it.

Top module: `tap_detector`

## Requirements
- R1: After reset, every single flag and double flag is 0, `int_active` is 0 and `int_line` is at its inactive level.
- R2: A pulse starts on an axis only on a `sample_vld` cycle where that axis's magnitude is strictly greater than its own threshold. The threshold for axis i sits in bits [8*i+7:8*i] of `cfg_thresh`. Axes act independently.
- R3: With time limit L, a pulse is a valid tap only if a sample with magnitude at or below the threshold arrives after fewer than L ticks have passed since the rising sample. On the L-th tick the pulse is dropped with no event. The axis then waits for a sample at or below the threshold before it can arm again.
- R4: With double taps disabled on an axis, a valid tap sets that axis's single flag in the cycle of its falling sample, provided single taps are enabled.
- R5: With double taps enabled, every sample in the first `cfg_latency` ticks after a valid first tap is ignored. A latency of 0 ends the quiet period in the next cycle.
- R6: A rising sample that arrives after the quiet period ends, and before `cfg_window` further ticks have passed, starts a second pulse. If that pulse falls within the time limit, the axis's double flag is set.
- R7: If the window expires without a second rising sample, the axis returns to idle. Its single flag is set on the expiring tick only if single taps are enabled.
- R8: With `cfg_latch` at 0, flags clear on the next `sample_vld`. An event in that same cycle sets its flag anyway.
- R9: With `cfg_latch` at 1, flags hold until `src_rd` is pulsed. An event in the read cycle leaves its flag set.
- R10: `int_active` is 1 exactly when any flag is set. `int_line` equals `int_active` when the parameter INT_ACTIVE_LOW is 0.
- R11: An axis with both its single and double enable bits at 0 never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | New magnitudes present on `mag` |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| mag | input | NAXES*MAG_W | Per-axis magnitudes, axis i in slice i |
| cfg_thresh | input | NAXES*MAG_W | Per-axis thresholds, axis i in slice i |
| cfg_limit | input | TIME_W | Pulse time limit in ticks |
| cfg_latency | input | TIME_W | Quiet period after the first tap, in ticks |
| cfg_window | input | TIME_W | Second-tap window, in ticks |
| cfg_single_en | input | NAXES | Per-axis single-tap enable |
| cfg_double_en | input | NAXES | Per-axis double-tap enable |
| cfg_latch | input | 1 | 1: flags hold until read |
| src_rd | input | 1 | Read strobe that clears latched flags |
| single_flag | output | NAXES | Per-axis single-tap flags |
| double_flag | output | NAXES | Per-axis double-tap flags |
| int_active | output | 1 | Any flag set |
| int_line | output | 1 | Interrupt line, polarity set by INT_ACTIVE_LOW |

## Verification
The hardest situation to reach is a second rising sample that lands right at the edges of the quiet period and the window. These edges sit on particular ticks, counted from a falling sample that must itself come within the time limit. The bench sweeps the tick gap between the first tap and the second rising sample across all values from zero to past the end of the window. For each gap it computes arithmetically whether the rise falls in the quiet period, in the window or after expiry. The bench also sweeps the pulse length across the time limit, and magnitudes across each axis's threshold, under every enable mask.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int CMP_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PULSE1 = 3'd1,
        ST_QUIET  = 3'd2,
        ST_WAIT2  = 3'd3,
        ST_PULSE2 = 3'd4,
        ST_HOLD   = 3'd5
    } tap_state_e;

    typedef struct packed {
        logic single_hit;
        logic double_hit;
    } tap_evt_t;

    // True when the tick being taken now completes an interval of 'limit' ticks.
    function automatic logic lapse_done(input logic [CMP_W-1:0] elapsed,
                                        input logic [CMP_W-1:0] limit);
        return (elapsed + CMP_W'(1)) >= limit;
    endfunction

endpackage

// File: rtl/tap_axis_seq.sv
module tap_axis_seq
    import tap_pkg::*;
#(
    parameter int MAG_W  = 8,
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_vld,
    input  logic              ms_tick,
    input  logic [MAG_W-1:0]  mag,
    input  logic [MAG_W-1:0]  thresh,
    input  logic [TIME_W-1:0] lim_pulse,
    input  logic [TIME_W-1:0] lim_quiet,
    input  logic [TIME_W-1:0] lim_window,
    input  logic              single_en,
    input  logic              double_en,
    output tap_evt_t          evt
);

    tap_state_e        state_q, state_d;
    logic [TIME_W-1:0] cnt_q, cnt_d;
    logic              above;
    logic              armed;
    logic              pulse_over;
    logic              quiet_over;
    logic              window_over;

    assign above       = mag > thresh;
    assign armed       = single_en | double_en;
    assign pulse_over  = lapse_done(CMP_W'(cnt_q), CMP_W'(lim_pulse));
    assign quiet_over  = lapse_done(CMP_W'(cnt_q), CMP_W'(lim_quiet));
    assign window_over = lapse_done(CMP_W'(cnt_q), CMP_W'(lim_window));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        evt     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (sample_vld && above && armed) begin
                    state_d = ST_PULSE1;
                    cnt_d   = '0;
                end
            end
            ST_PULSE1: begin
                if (sample_vld && !above) begin
                    cnt_d = '0;
                    if (double_en) begin
                        state_d = ST_QUIET;
                    end else begin
                        evt.single_hit = single_en;
                        state_d        = ST_IDLE;
                    end
                end else if (ms_tick) begin
                    if (pulse_over) state_d = ST_HOLD;
                    else            cnt_d   = cnt_q + TIME_W'(1);
                end
            end
            ST_QUIET: begin
                if (lim_quiet == '0) begin
                    state_d = ST_WAIT2;
                    cnt_d   = '0;
                end else if (ms_tick) begin
                    if (quiet_over) begin
                        state_d = ST_WAIT2;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + TIME_W'(1);
                    end
                end
            end
            ST_WAIT2: begin
                if (sample_vld && above) begin
                    state_d = ST_PULSE2;
                    cnt_d   = '0;
                end else if (ms_tick) begin
                    if (window_over) begin
                        evt.single_hit = single_en;
                        state_d        = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + TIME_W'(1);
                    end
                end
            end
            ST_PULSE2: begin
                if (sample_vld && !above) begin
                    evt.double_hit = double_en;
                    state_d        = ST_IDLE;
                end else if (ms_tick) begin
                    if (pulse_over) state_d = ST_HOLD;
                    else            cnt_d   = cnt_q + TIME_W'(1);
                end
            end
            ST_HOLD: begin
                if (sample_vld && !above) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/tap_flag_bank.sv
module tap_flag_bank #(
    parameter int NAXES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_vld,
    input  logic             src_rd,
    input  logic             latch_mode,
    input  logic [NAXES-1:0] single_evt,
    input  logic [NAXES-1:0] double_evt,
    output logic [NAXES-1:0] single_q,
    output logic [NAXES-1:0] double_q
);

    logic wipe;

    assign wipe = latch_mode ? src_rd : sample_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            single_q <= '0;
            double_q <= '0;
        end else begin
            single_q <= (wipe ? '0 : single_q) | single_evt;
            double_q <= (wipe ? '0 : double_q) | double_evt;
        end
    end

endmodule

// File: rtl/tap_detector.sv
module tap_detector
    import tap_pkg::*;
#(
    parameter int NAXES          = 3,
    parameter int MAG_W          = 8,
    parameter int TIME_W         = 8,
    parameter bit INT_ACTIVE_LOW = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sample_vld,
    input  logic                   ms_tick,
    input  logic [NAXES*MAG_W-1:0] mag,
    input  logic [NAXES*MAG_W-1:0] cfg_thresh,
    input  logic [TIME_W-1:0]      cfg_limit,
    input  logic [TIME_W-1:0]      cfg_latency,
    input  logic [TIME_W-1:0]      cfg_window,
    input  logic [NAXES-1:0]       cfg_single_en,
    input  logic [NAXES-1:0]       cfg_double_en,
    input  logic                   cfg_latch,
    input  logic                   src_rd,
    output logic [NAXES-1:0]       single_flag,
    output logic [NAXES-1:0]       double_flag,
    output logic                   int_active,
    output logic                   int_line
);

    logic [NAXES-1:0] single_evt;
    logic [NAXES-1:0] double_evt;

    for (genvar ax = 0; ax < NAXES; ax++) begin : g_axis
        tap_evt_t axis_evt;

        tap_axis_seq #(
            .MAG_W  (MAG_W),
            .TIME_W (TIME_W)
        ) u_seq (
            .clk        (clk),
            .rst        (rst),
            .sample_vld (sample_vld),
            .ms_tick    (ms_tick),
            .mag        (mag[ax*MAG_W +: MAG_W]),
            .thresh     (cfg_thresh[ax*MAG_W +: MAG_W]),
            .lim_pulse  (cfg_limit),
            .lim_quiet  (cfg_latency),
            .lim_window (cfg_window),
            .single_en  (cfg_single_en[ax]),
            .double_en  (cfg_double_en[ax]),
            .evt        (axis_evt)
        );

        assign single_evt[ax] = axis_evt.single_hit;
        assign double_evt[ax] = axis_evt.double_hit;
    end

    tap_flag_bank #(
        .NAXES (NAXES)
    ) u_flags (
        .clk        (clk),
        .rst        (rst),
        .sample_vld (sample_vld),
        .src_rd     (src_rd),
        .latch_mode (cfg_latch),
        .single_evt (single_evt),
        .double_evt (double_evt),
        .single_q   (single_flag),
        .double_q   (double_flag)
    );

    assign int_active = (|single_flag) | (|double_flag);
    assign int_line   = int_active ^ INT_ACTIVE_LOW;

endmodule

// File: rtl/tap_detector_chk.sv
module tap_detector_chk #(
    parameter int NAXES          = 3,
    parameter int MAG_W          = 8,
    parameter int TIME_W         = 8,
    parameter bit INT_ACTIVE_LOW = 1'b0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   sample_vld,
    input logic                   ms_tick,
    input logic [NAXES*MAG_W-1:0] mag,
    input logic [NAXES*MAG_W-1:0] cfg_thresh,
    input logic [TIME_W-1:0]      cfg_limit,
    input logic [TIME_W-1:0]      cfg_latency,
    input logic [TIME_W-1:0]      cfg_window,
    input logic [NAXES-1:0]       cfg_single_en,
    input logic [NAXES-1:0]       cfg_double_en,
    input logic                   cfg_latch,
    input logic                   src_rd,
    input logic [NAXES-1:0]       single_flag,
    input logic [NAXES-1:0]       double_flag,
    input logic                   int_active,
    input logic                   int_line
);

    // R1: the first cycle after reset shows no flag and no interrupt
    a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (single_flag == '0 && double_flag == '0 && !int_active));

    // R9: in latched mode without a read, no set flag drops
    a_r9_latched_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_latch && !src_rd) |=>
            (((single_flag & $past(single_flag)) == $past(single_flag)) &&
             ((double_flag & $past(double_flag)) == $past(double_flag))));

    // R11: a single flag only rises on an axis whose single enable was set
    a_r11_single_needs_enable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((single_flag & ~$past(single_flag) & ~$past(cfg_single_en)) == '0));

    // R6: a double flag only rises on an axis whose double enable was set
    a_r6_double_needs_enable: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((double_flag & ~$past(double_flag) & ~$past(cfg_double_en)) == '0));

endmodule

bind tap_detector tap_detector_chk #(
    .NAXES          (NAXES),
    .MAG_W          (MAG_W),
    .TIME_W         (TIME_W),
    .INT_ACTIVE_LOW (INT_ACTIVE_LOW)
) u_chk (.*);

// File: tb/tap_detector_test.sv
module tap_detector_test;

    localparam int CLK_PERIOD = 10;
    localparam int NAXES      = 3;
    localparam int MAG_W      = 8;
    localparam int TIME_W     = 8;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   sample_vld = 1'b0;
    logic                   ms_tick = 1'b0;
    logic [NAXES*MAG_W-1:0] mag = '0;
    logic [NAXES*MAG_W-1:0] cfg_thresh = '0;
    logic [TIME_W-1:0]      cfg_limit = '0;
    logic [TIME_W-1:0]      cfg_latency = '0;
    logic [TIME_W-1:0]      cfg_window = '0;
    logic [NAXES-1:0]       cfg_single_en = '0;
    logic [NAXES-1:0]       cfg_double_en = '0;
    logic                   cfg_latch = 1'b0;
    logic                   src_rd = 1'b0;
    logic [NAXES-1:0]       single_flag;
    logic [NAXES-1:0]       double_flag;
    logic                   int_active;
    logic                   int_line;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_detector #(
        .NAXES (NAXES), .MAG_W (MAG_W), .TIME_W (TIME_W), .INT_ACTIVE_LOW (1'b0)
    ) uut (
        .clk (clk), .rst (rst), .sample_vld (sample_vld), .ms_tick (ms_tick),
        .mag (mag), .cfg_thresh (cfg_thresh), .cfg_limit (cfg_limit),
        .cfg_latency (cfg_latency), .cfg_window (cfg_window),
        .cfg_single_en (cfg_single_en), .cfg_double_en (cfg_double_en),
        .cfg_latch (cfg_latch), .src_rd (src_rd),
        .single_flag (single_flag), .double_flag (double_flag),
        .int_active (int_active), .int_line (int_line)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock with the given strobes; outputs are read 1 time unit after the edge.
    task automatic step(input logic v, input logic t, input logic [7:0] m, input logic rd);
        sample_vld = v;
        ms_tick    = t;
        mag        = {m, m, m};
        src_rd     = rd;
        @(posedge clk);
        #1;
        sample_vld = 1'b0;
        ms_tick    = 1'b0;
        src_rd     = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 8'd0, 1'b0);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1 single", int'(single_flag), 0);
        check("R1 double", int'(double_flag), 0);
        check("R1 int_active", int'(int_active), 0);
        check("R1 int_line", int'(int_line), 0);

        // R3/R4: pulse length sweep across the time limit, single only on axis 0
        cfg_thresh    = {8'd50, 8'd50, 8'd50};
        cfg_limit     = 8'd3;
        cfg_single_en = 3'b001;
        cfg_double_en = 3'b000;
        for (int d = 0; d <= 5; d++) begin
            step(1'b1, 1'b0, 8'd100, 1'b0);
            ticks(d);
            step(1'b1, 1'b0, 8'd0, 1'b0);
            check("R3/R4 single after pulse", int'(single_flag), (d < 3) ? 1 : 0);
            check("R10 int_active", int'(int_active), (d < 3) ? 1 : 0);
            check("R10 int_line", int'(int_line), (d < 3) ? 1 : 0);
            step(1'b1, 1'b0, 8'd0, 1'b0);
            check("R8 cleared by sample", int'(single_flag), 0);
        end

        // R5/R6: gap sweep for the second rising sample
        cfg_limit     = 8'd4;
        cfg_latency   = 8'd2;
        cfg_window    = 8'd3;
        cfg_single_en = 3'b001;
        cfg_double_en = 3'b001;
        for (int g = 0; g <= 7; g++) begin
            step(1'b1, 1'b0, 8'd100, 1'b0);
            step(1'b1, 1'b0, 8'd0, 1'b0);
            ticks(g);
            step(1'b1, 1'b0, 8'd100, 1'b0);
            step(1'b1, 1'b0, 8'd0, 1'b0);
            check("R5/R6 double vs gap", int'(double_flag), (g >= 2 && g < 5) ? 1 : 0);
            check("R8 single clear at second tap", int'(single_flag), 0);
            ticks(12);
            step(1'b1, 1'b0, 8'd0, 1'b0);
            check("R8 flags clear", int'(single_flag | double_flag), 0);
        end

        // R7: window expiry reports a single tap on the exact tick
        for (int en = 1; en >= 0; en--) begin
            cfg_single_en = en[0] ? 3'b001 : 3'b000;
            step(1'b1, 1'b0, 8'd100, 1'b0);
            step(1'b1, 1'b0, 8'd0, 1'b0);
            for (int k = 1; k <= 7; k++) begin
                ticks(1);
                check("R7 single at expiry", int'(single_flag), (en == 1 && k >= 5) ? 1 : 0);
                check("R7 no double at expiry", int'(double_flag), 0);
            end
            step(1'b1, 1'b0, 8'd0, 1'b0);
        end

        // R5: latency 0 opens the window at once
        cfg_single_en = 3'b001;
        cfg_latency   = 8'd0;
        step(1'b1, 1'b0, 8'd100, 1'b0);
        step(1'b1, 1'b0, 8'd0, 1'b0);
        step(1'b0, 1'b0, 8'd0, 1'b0);
        step(1'b1, 1'b0, 8'd100, 1'b0);
        step(1'b1, 1'b0, 8'd0, 1'b0);
        check("R5 zero latency double", int'(double_flag), 1);
        step(1'b1, 1'b0, 8'd0, 1'b0);

        // R2/R11: magnitude sweep against per-axis thresholds, all enable masks
        cfg_thresh    = {8'd30, 8'd20, 8'd10};
        cfg_double_en = 3'b000;
        for (int mask = 0; mask < 8; mask++) begin
            cfg_single_en = mask[2:0];
            for (int m = 0; m <= 40; m += 5) begin
                automatic int exp_v = ((m > 10) ? 1 : 0) | ((m > 20) ? 2 : 0) | ((m > 30) ? 4 : 0);
                step(1'b1, 1'b0, 8'(m), 1'b0);
                step(1'b1, 1'b0, 8'd0, 1'b0);
                check("R2/R11 per-axis threshold", int'(single_flag), exp_v & mask);
                step(1'b1, 1'b0, 8'd0, 1'b0);
            end
        end

        // R9: latched flags hold across samples, clear on read, event wins over read
        cfg_thresh    = {8'd50, 8'd50, 8'd50};
        cfg_single_en = 3'b001;
        cfg_latch     = 1'b1;
        step(1'b1, 1'b0, 8'd100, 1'b0);
        step(1'b1, 1'b0, 8'd0, 1'b0);
        for (int s = 0; s < 3; s++) begin
            step(1'b1, 1'b0, 8'd0, 1'b0);
            check("R9 latched hold", int'(single_flag), 1);
        end
        check("R10 int_active latched", int'(int_active), 1);
        step(1'b0, 1'b0, 8'd0, 1'b1);
        check("R9 read clears", int'(single_flag), 0);
        check("R10 int_line idle", int'(int_line), 0);
        step(1'b1, 1'b0, 8'd100, 1'b0);
        step(1'b1, 1'b0, 8'd0, 1'b1);
        check("R9 event wins over read", int'(single_flag), 1);
        step(1'b0, 1'b0, 8'd0, 1'b1);
        check("R9 second read clears", int'(single_flag), 0);

        summary();
        $finish;
    end

endmodule